// File: doc/BRIEF.md
# Portrait RGB Panel Scan Timing Generator

This block produces the scan timing for a parallel RGB panel that is mounted in portrait orientation. It runs in the pixel clock domain. On every enabled clock it moves one pixel along the current line. It drives an active-low horizontal sync, an active-low vertical sync and an active-high data-enable. It also gives the column and row of the pixel being presented. The pixel source sits outside the block. It uses the coordinates to fetch the matching colour and uses the data-enable to know when the panel takes it in.

Each line has 480 visible pixels, then 24 clocks of front porch, 8 clocks of sync and 8 clocks of back porch, for 520 clocks in all. Each frame has the same order in lines: 640 visible lines, 4 front-porch lines, 2 sync lines and 2 back-porch lines, for 648 lines in all. At the nominal pixel clock of about 22.15 MHz this gives a refresh rate close to 66 Hz.

The syncs and coordinates change on the rising clock edge. The data-enable is launched on the falling edge, so the panel sees it at the same point as pixel data that is also launched on that edge. A one-clock start-of-frame pulse marks pixel 0 of line 0. All segment lengths are parameters whose defaults are the values above.

Top module: `dpi_frame_timer`

## Requirements
- R1: One clock edge with `rst` high sets `pix_x` and `line_y` to 0, drives `hsync_n` and `vsync_n` high, and drives `de` and `sof` low. These values stay in place until `en` is high on an edge where `rst` is low.
- R2: While `en` is high, `pix_x` steps by one on every rising edge from 0 up to H_ACTIVE+H_FRONT+H_SYNC+H_BACK-1 (519) and then wraps to 0. `line_y` steps by one each time `pix_x` wraps, and it wraps to 0 after V_ACTIVE+V_FRONT+V_SYNC+V_BACK-1 (647).
- R3: `de` is 1 exactly when `pix_x` < H_ACTIVE (480) and `line_y` < V_ACTIVE (640). Otherwise it is 0.
- R4: `hsync_n` is 0 exactly while `pix_x` is in H_ACTIVE+H_FRONT .. H_ACTIVE+H_FRONT+H_SYNC-1 (504 to 511). Otherwise it is 1.
- R5: `vsync_n` is 0 for every pixel of lines V_ACTIVE+V_FRONT .. V_ACTIVE+V_FRONT+V_SYNC-1 (644 and 645). Otherwise it is 1.
- R6: `sof` is high for exactly one clock whenever the presented position is pixel 0 of line 0. This includes the first enabled clock after reset, which always presents that position.
- R7: On a rising edge where `en` is 0 and `rst` is 0, `pix_x`, `line_y`, `hsync_n`, `vsync_n` and `de` hold their values and `sof` goes to 0.
- R8: `pix_x`, `line_y`, `hsync_n`, `vsync_n` and `sof` update on the rising clock edge. `de` takes its new value on the following falling edge, half a clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the scan by one pixel on this edge |
| pix_x | output | $clog2(H total) | Column of the presented pixel |
| line_y | output | $clog2(V total) | Row of the presented pixel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, active high, launched on the falling edge |
| sof | output | 1 | Start of frame, one clock at pixel 0 of line 0 |

## Verification
The bench samples the last visible pixel and the first blanking pixel of a line and of a frame. It also samples both ends of the horizontal sync window and the line before and after vertical sync. An off-by-one in any segment boundary would therefore move an edge of `de` or a sync by one position, and a sample would show it. The bench probes `de` both before and after the falling edge at the start of a visible line, so a design that launched it on the rising edge would show 1 half a clock too early. Further checks catch three other faults: a pause that lets the counters creep or leaves `sof` stuck high, a first frame after reset that skips pixel 0, and a reset in the middle of a frame that leaves a sync asserted.

// File: rtl/dpi_timing_pkg.sv
package dpi_timing_pkg;

   // Position of a counter inside its scan period.
   typedef enum logic [1:0] {
      SEG_ACTIVE = 2'd0,
      SEG_FRONT  = 2'd1,
      SEG_SYNC   = 2'd2,
      SEG_BACK   = 2'd3
   } seg_e;

   // Width of a counter that must reach total-1, never below one bit.
   function automatic int unsigned span_width(input int unsigned total);
      return (total < 2) ? 1 : $clog2(total);
   endfunction

endpackage

// File: rtl/dpi_axis_counter.sv
// Wrapping position counter for one scan axis. It exposes the value it
// will take after the current edge so that registered decodes can line up.
module dpi_axis_counter #(
   parameter int unsigned TOTAL = 520,
   parameter int unsigned W     = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cnt_nxt,
   output logic         at_last
);
   localparam logic [W-1:0] LAST = W'(TOTAL - 1);

   initial begin
      assert (TOTAL >= 2) else $error("axis period must be at least two");
      assert ((1 << W) >= TOTAL) else $error("axis counter too narrow");
   end

   always_comb begin
      at_last = (cnt_q == LAST);
      if (!adv)
         cnt_nxt = cnt_q;
      else if (at_last)
         cnt_nxt = '0;
      else
         cnt_nxt = cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else
         cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/dpi_segment_decode.sv
// Maps a position on one axis to its segment: visible, front porch,
// sync, back porch, in that order.
module dpi_segment_decode
   import dpi_timing_pkg::*;
#(
   parameter int unsigned ACT  = 480,
   parameter int unsigned FP   = 24,
   parameter int unsigned SYN  = 8,
   parameter int unsigned BP   = 8,
   parameter int unsigned W    = 10
) (
   input  logic [W-1:0] pos,
   output seg_e         seg
);
   localparam int unsigned TOT = ACT + FP + SYN + BP;
   localparam logic [W-1:0] FP_START   = W'(ACT);
   localparam logic [W-1:0] SYN_START  = W'(ACT + FP);
   localparam logic [W-1:0] BP_START   = W'(ACT + FP + SYN);

   initial begin
      assert (ACT > 0 && SYN > 0) else $error("visible and sync spans must be non-empty");
      assert ((1 << W) >= TOT) else $error("segment decoder too narrow");
   end

   always_comb begin
      if (pos < FP_START)
         seg = SEG_ACTIVE;
      else if (pos < SYN_START)
         seg = SEG_FRONT;
      else if (pos < BP_START)
         seg = SEG_SYNC;
      else
         seg = SEG_BACK;
   end
endmodule

// File: rtl/dpi_edge_launch.sv
// Retimes a rising-edge signal onto the edge the panel samples from.
module dpi_edge_launch #(
   parameter bit FALLING = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (FALLING) begin : g_fall
         logic q_r;
         always_ff @(negedge clk) begin
            if (rst)
               q_r <= 1'b0;
            else
               q_r <= d;
         end
         assign q = q_r;
      end else begin : g_rise
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/dpi_frame_timer.sv
module dpi_frame_timer
   import dpi_timing_pkg::*;
#(
   parameter int unsigned H_ACTIVE        = 480,
   parameter int unsigned H_FRONT         = 24,
   parameter int unsigned H_SYNC          = 8,
   parameter int unsigned H_BACK          = 8,
   parameter int unsigned V_ACTIVE        = 640,
   parameter int unsigned V_FRONT         = 4,
   parameter int unsigned V_SYNC          = 2,
   parameter int unsigned V_BACK          = 2,
   parameter bit          SYNC_ACTIVE_LOW = 1'b1,
   parameter bit          DE_ON_FALLING   = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic [span_width(H_ACTIVE+H_FRONT+H_SYNC+H_BACK)-1:0] pix_x,
   output logic [span_width(V_ACTIVE+V_FRONT+V_SYNC+V_BACK)-1:0] line_y,
   output logic hsync_n,
   output logic vsync_n,
   output logic de,
   output logic sof
);
   localparam int unsigned H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
   localparam int unsigned V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
   localparam int unsigned XW      = span_width(H_TOTAL);
   localparam int unsigned YW      = span_width(V_TOTAL);

   initial begin
      assert (H_ACTIVE > 0 && V_ACTIVE > 0) else $error("visible area must be non-empty");
      assert (H_SYNC > 0 && V_SYNC > 0) else $error("sync pulses must be non-empty");
      assert (H_TOTAL > 1) else $error("line must be longer than one clock");
   end

   // The first enabled edge after reset presents (0,0) without advancing.
   logic running;
   logic h_adv, v_adv;
   logic h_last, v_last;
   logic [XW-1:0] x_q, x_nxt;
   logic [YW-1:0] y_q, y_nxt;
   seg_e h_seg, v_seg;

   always_ff @(posedge clk) begin
      if (rst)
         running <= 1'b0;
      else if (en)
         running <= 1'b1;
   end

   assign h_adv = en & running;
   assign v_adv = h_adv & h_last;

   dpi_axis_counter #(.TOTAL(H_TOTAL), .W(XW)) u_hcnt (
      .clk     (clk),
      .rst     (rst),
      .adv     (h_adv),
      .cnt_q   (x_q),
      .cnt_nxt (x_nxt),
      .at_last (h_last)
   );

   dpi_axis_counter #(.TOTAL(V_TOTAL), .W(YW)) u_vcnt (
      .clk     (clk),
      .rst     (rst),
      .adv     (v_adv),
      .cnt_q   (y_q),
      .cnt_nxt (y_nxt),
      .at_last (v_last)
   );

   // Decode the upcoming position so registered outputs meet the counters.
   dpi_segment_decode #(.ACT(H_ACTIVE), .FP(H_FRONT), .SYN(H_SYNC), .BP(H_BACK), .W(XW)) u_hdec (
      .pos (x_nxt),
      .seg (h_seg)
   );

   dpi_segment_decode #(.ACT(V_ACTIVE), .FP(V_FRONT), .SYN(V_SYNC), .BP(V_BACK), .W(YW)) u_vdec (
      .pos (y_nxt),
      .seg (v_seg)
   );

   logic hs_act, vs_act, de_rise, sof_q;
   logic origin_nxt;

   assign origin_nxt = (x_nxt == '0) && (y_nxt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         hs_act  <= 1'b0;
         vs_act  <= 1'b0;
         de_rise <= 1'b0;
         sof_q   <= 1'b0;
      end else if (en) begin
         hs_act  <= (h_seg == SEG_SYNC);
         vs_act  <= (v_seg == SEG_SYNC);
         de_rise <= (h_seg == SEG_ACTIVE) && (v_seg == SEG_ACTIVE);
         sof_q   <= origin_nxt && !(running && !h_adv);
      end else begin
         sof_q   <= 1'b0;
      end
   end

   generate
      if (SYNC_ACTIVE_LOW) begin : g_sync_low
         assign hsync_n = ~hs_act;
         assign vsync_n = ~vs_act;
      end else begin : g_sync_high
         assign hsync_n = hs_act;
         assign vsync_n = vs_act;
      end
   endgenerate

   dpi_edge_launch #(.FALLING(DE_ON_FALLING)) u_de_launch (
      .clk (clk),
      .rst (rst),
      .d   (de_rise),
      .q   (de)
   );

   assign pix_x  = x_q;
   assign line_y = y_q;
   assign sof    = sof_q;

   // The vertical wrap flag only matters to the counter itself.
   logic unused_v_last;
   assign unused_v_last = v_last;
endmodule

// File: rtl/dpi_frame_timer_chk.sv
module dpi_frame_timer_chk #(
   parameter int unsigned H_ACTIVE        = 480,
   parameter int unsigned H_FRONT         = 24,
   parameter int unsigned H_SYNC          = 8,
   parameter int unsigned H_BACK          = 8,
   parameter int unsigned V_ACTIVE        = 640,
   parameter int unsigned V_FRONT         = 4,
   parameter int unsigned V_SYNC          = 2,
   parameter int unsigned V_BACK          = 2,
   parameter bit          SYNC_ACTIVE_LOW = 1'b1,
   parameter int unsigned XW              = 10,
   parameter int unsigned YW              = 10
) (
   input logic          clk,
   input logic          rst,
   input logic          en,
   input logic [XW-1:0] pix_x,
   input logic [YW-1:0] line_y,
   input logic          hsync_n,
   input logic          vsync_n,
   input logic          de,
   input logic          sof
);
   localparam int unsigned H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
   localparam int unsigned V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
   localparam int unsigned HS_LO   = H_ACTIVE + H_FRONT;
   localparam int unsigned HS_HI   = H_ACTIVE + H_FRONT + H_SYNC;
   localparam int unsigned VS_LO   = V_ACTIVE + V_FRONT;
   localparam int unsigned VS_HI   = V_ACTIVE + V_FRONT + V_SYNC;

   logic hs_on, vs_on;
   assign hs_on = SYNC_ACTIVE_LOW ? !hsync_n : hsync_n;
   assign vs_on = SYNC_ACTIVE_LOW ? !vsync_n : vsync_n;

   AST_RESET_STATE: assert property (@(posedge clk) rst |=> (pix_x == '0 && line_y == '0 && !hs_on && !vs_on && !de && !sof)); // R1
   AST_X_WRAP: assert property (@(posedge clk) disable iff (rst) (en && int'(pix_x) == H_TOTAL - 1) |=> (pix_x == '0)); // R2
   AST_Y_STEP: assert property (@(posedge clk) disable iff (rst) (en && int'(pix_x) == H_TOTAL - 1 && int'(line_y) != V_TOTAL - 1) |=> (int'(line_y) == int'($past(line_y)) + 1)); // R2
   AST_DE_IN_ACTIVE: assert property (@(posedge clk) disable iff (rst) de |-> (int'(pix_x) < H_ACTIVE && int'(line_y) < V_ACTIVE)); // R3
   AST_HS_WINDOW: assert property (@(posedge clk) disable iff (rst) hs_on == (int'(pix_x) >= HS_LO && int'(pix_x) < HS_HI)); // R4
   AST_VS_WINDOW: assert property (@(posedge clk) disable iff (rst) vs_on == (int'(line_y) >= VS_LO && int'(line_y) < VS_HI)); // R5
   AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (rst) sof |-> (pix_x == '0 && line_y == '0)); // R6
   AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (rst) sof |=> !sof); // R6
   AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst) !en |=> ($stable(pix_x) && $stable(line_y) && $stable(hsync_n) && $stable(vsync_n) && !sof)); // R7
endmodule

bind dpi_frame_timer dpi_frame_timer_chk #(
   .H_ACTIVE        (H_ACTIVE),
   .H_FRONT         (H_FRONT),
   .H_SYNC          (H_SYNC),
   .H_BACK          (H_BACK),
   .V_ACTIVE        (V_ACTIVE),
   .V_FRONT         (V_FRONT),
   .V_SYNC          (V_SYNC),
   .V_BACK          (V_BACK),
   .SYNC_ACTIVE_LOW (SYNC_ACTIVE_LOW),
   .XW              (XW),
   .YW              (YW)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .en      (en),
   .pix_x   (pix_x),
   .line_y  (line_y),
   .hsync_n (hsync_n),
   .vsync_n (vsync_n),
   .de      (de),
   .sof     (sof)
);

// File: tb/dpi_frame_timer_bench.sv
`timescale 1ns/1ps
module dpi_frame_timer_bench;
   localparam int H_ACT = 480, H_FP = 24, H_SY = 8, H_BP = 8;
   localparam int V_ACT = 12,  V_FP = 4,  V_SY = 2, V_BP = 2;
   localparam int H_TOT = H_ACT + H_FP + H_SY + H_BP;
   localparam int V_TOT = V_ACT + V_FP + V_SY + V_BP;
   localparam int FRAME = H_TOT * V_TOT;
   localparam int XW = $clog2(H_TOT);
   localparam int YW = $clog2(V_TOT);

   typedef struct packed {
      int k;
      int x;
      int y;
      bit de;
      bit hs_n;
      bit vs_n;
      bit sof;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t TBL [NV] = '{
      '{0,     0,   0,  1'b1, 1'b1, 1'b1, 1'b1},
      '{479,   479, 0,  1'b1, 1'b1, 1'b1, 1'b0},
      '{480,   480, 0,  1'b0, 1'b1, 1'b1, 1'b0},
      '{503,   503, 0,  1'b0, 1'b1, 1'b1, 1'b0},
      '{504,   504, 0,  1'b0, 1'b0, 1'b1, 1'b0},
      '{511,   511, 0,  1'b0, 1'b0, 1'b1, 1'b0},
      '{512,   512, 0,  1'b0, 1'b1, 1'b1, 1'b0},
      '{519,   519, 0,  1'b0, 1'b1, 1'b1, 1'b0},
      '{520,   0,   1,  1'b1, 1'b1, 1'b1, 1'b0},
      '{6199,  479, 11, 1'b1, 1'b1, 1'b1, 1'b0},
      '{6240,  0,   12, 1'b0, 1'b1, 1'b1, 1'b0},
      '{7900,  100, 15, 1'b0, 1'b1, 1'b1, 1'b0},
      '{8320,  0,   16, 1'b0, 1'b1, 1'b0, 1'b0},
      '{8825,  505, 16, 1'b0, 1'b0, 1'b0, 1'b0},
      '{9359,  519, 17, 1'b0, 1'b1, 1'b0, 1'b0},
      '{9360,  0,   18, 1'b0, 1'b1, 1'b1, 1'b0},
      '{10399, 519, 19, 1'b0, 1'b1, 1'b1, 1'b0},
      '{10400, 0,   0,  1'b1, 1'b1, 1'b1, 1'b1},
      '{10405, 5,   0,  1'b1, 1'b1, 1'b1, 1'b0}
   };

   logic clk = 1'b0;
   logic rst;
   logic en;
   logic [XW-1:0] pix_x;
   logic [YW-1:0] line_y;
   logic hsync_n, vsync_n, de, sof;

   int checks = 0;
   int errors = 0;
   int k;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dpi_frame_timer #(
      .H_ACTIVE(H_ACT), .H_FRONT(H_FP), .H_SYNC(H_SY), .H_BACK(H_BP),
      .V_ACTIVE(V_ACT), .V_FRONT(V_FP), .V_SYNC(V_SY), .V_BACK(V_BP)
   ) u_dpi_frame_timer (
      .clk(clk), .rst(rst), .en(en),
      .pix_x(pix_x), .line_y(line_y),
      .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .sof(sof)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at time %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #6;
   endtask

   task automatic run_to(input int target);
      while (k < target) begin
         step();
         k++;
      end
   endtask

   task automatic check_reset_state(input string tag);
      check({tag, " x"},   32'(pix_x),  0);
      check({tag, " y"},   32'(line_y), 0);
      check({tag, " hs_n"}, 32'(hsync_n), 1);
      check({tag, " vs_n"}, 32'(vsync_n), 1);
      check({tag, " de"},   32'(de), 0);
      check({tag, " sof"},  32'(sof), 0);
   endtask

   initial begin
      rst = 1'b1;
      en  = 1'b0;
      k   = -1;
      repeat (3) @(posedge clk);
      #6;
      rst = 1'b0;
      step();
      check_reset_state("R1 after reset, en low");

      en = 1'b1;
      for (int i = 0; i < NV; i++) begin
         run_to(TBL[i].k);
         check("R2 pix_x",        32'(pix_x),   32'(TBL[i].x));
         check("R2 line_y",       32'(line_y),  32'(TBL[i].y));
         check("R3 de",           32'(de),      32'(TBL[i].de));
         check("R4 hsync_n",      32'(hsync_n), 32'(TBL[i].hs_n));
         check("R5 vsync_n",      32'(vsync_n), 32'(TBL[i].vs_n));
         check("R6 sof",          32'(sof),     32'(TBL[i].sof));
      end

      // R7: pause in the visible area
      run_to(FRAME + 100);
      check("R2 pre-pause x", 32'(pix_x), 100);
      en = 1'b0;
      repeat (4) step();
      check("R7 paused x",   32'(pix_x),  100);
      check("R7 paused y",   32'(line_y), 0);
      check("R7 paused de",  32'(de),     1);
      check("R7 paused sof", 32'(sof),    0);
      en = 1'b1;
      run_to(FRAME + 101);
      check("R7 resume x", 32'(pix_x), 101);

      // R7: pause inside horizontal sync
      run_to(FRAME + 506);
      check("R4 in sync", 32'(hsync_n), 0);
      en = 1'b0;
      repeat (3) step();
      check("R7 paused hs_n", 32'(hsync_n), 0);
      check("R7 paused x in sync", 32'(pix_x), 506);
      en = 1'b1;

      // R8: de follows the falling edge at the start of a visible line
      run_to(FRAME + 519);
      @(posedge clk);
      #2;
      check("R8 x before fall",  32'(pix_x), 0);
      check("R8 de before fall", 32'(de), 0);
      #4;
      k++;
      check("R8 de after fall", 32'(de), 1);
      check("R8 y new line",    32'(line_y), 1);

      // R6/R7: pause on the start-of-frame clock
      run_to(2 * FRAME);
      check("R6 sof second wrap", 32'(sof), 1);
      en = 1'b0;
      step();
      check("R7 sof drops when paused", 32'(sof), 0);
      check("R7 x held at origin", 32'(pix_x), 0);
      en = 1'b1;
      run_to(2 * FRAME + 1);
      check("R6 no sof after resume", 32'(sof), 0);
      check("R2 x after resume", 32'(pix_x), 1);

      // R1/R6: reset in mid-frame while enabled, then restart
      run_to(2 * FRAME + 200);
      rst = 1'b1;
      step();
      check_reset_state("R1 mid-frame reset");
      rst = 1'b0;
      step();
      check("R6 sof first enabled clock", 32'(sof), 1);
      check("R6 x first enabled clock",   32'(pix_x), 0);
      check("R3 de first enabled clock",  32'(de), 1);
      step();
      check("R2 x advances after restart", 32'(pix_x), 1);
      check("R6 sof one clock only",       32'(sof), 0);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule